// File: doc/BRIEF.md
# Serial Limit Store with Command Framing

This block holds the alarm thresholds used by a multi-channel monitor. A host talks to it over a three-wire serial link: an active-low select, a serial clock and a data line into the block. A fourth line carries data back to the host. Each select-low period is one transaction. The first four bits choose the operation. The block can write one threshold at a given address, stream in the whole table, or return one threshold on the data-out line. The table has sixteen 8-bit entries, two per channel. The entry at address 2×channel holds the lower bound and the entry at 2×channel+1 holds the upper bound.

The serial lines are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and the edges of the serial clock and of the select are found in the system clock domain. Comparison logic elsewhere reads the table through a separate registered parallel read port, which works in the same cycles as the serial side.

Top module: `limit_store_slave`

## Requirements
- R1: The first four bits after the select falls form the operation code, first bit as MSB. 1100 writes one entry, 1101 writes the whole table, and 1011 reads one entry.
- R2: For a single write, four address bits follow MSB-first, then eight data bits LSB-first. The word is stored at that address only when the select rises after the eighth data bit.
- R3: If the select rises during a single write before all eight data bits have arrived, the table is unchanged.
- R4: A whole-table write takes sixteen words, each LSB-first, with no address. They are stored at addresses 0 to 15 in order, so channel c lower bound is at 2c and upper bound is at 2c+1. Each word is stored as soon as its eighth bit arrives.
- R5: If the select rises partway through a whole-table write, the words already complete stay written and the partial word and later entries keep their old contents.
- R6: For a read, four address bits follow the code MSB-first. The addressed word then appears on ser_dout LSB-first. It changes on each falling serial clock edge, starting with the fall that follows the last address bit.
- R7: ser_dout is 0 during reset and 0 while the select is high (after the synchronizer latency).
- R8: Any other operation code leaves the table unchanged and keeps ser_dout at 0 for the rest of the frame.
- R9: rd_data shows the entry at rd_addr one clock after rd_addr is sampled. If the serial side writes that same entry in the same cycle, rd_data shows the previous contents in that cycle and the new contents from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock from host (asynchronous) |
| ser_cs_n | input | 1 | Active-low transaction select (asynchronous) |
| ser_din | input | 1 | Serial data from host |
| ser_dout | output | 1 | Serial read data to host, registered |
| rd_addr | input | 4 | Parallel read address |
| rd_data | output | 8 | Parallel read data, one cycle latency |

## Verification
A serial write to the table and a parallel read of the same entry can land in the same system clock cycle. The bench holds rd_addr on the target entry while a single write completes. It then raises the select on a known clock and counts the synchronizer and framing registers to find the exact cycle in which the table is written. In that cycle rd_data must still show the old word, and the new word must appear exactly one cycle later. This distinguishes read-first behaviour from write-first behaviour and from a shifted write cycle.

// File: rtl/limit_store_pkg.sv
package limit_store_pkg;

  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_WRITE_ONE = 4'b1100;
  localparam logic [OP_W-1:0] OP_WRITE_ALL = 4'b1101;
  localparam logic [OP_W-1:0] OP_READ_ONE  = 4'b1011;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OPCODE,
    ST_WADDR,
    ST_WDATA,
    ST_HOLD,
    ST_BULK,
    ST_RADDR,
    ST_RDOUT,
    ST_SKIP
  } frame_state_e;

endpackage

// File: rtl/limit_in_sync.sv
module limit_in_sync #(
  parameter int W = 3,
  parameter int EDGE_W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      async_in,
  output logic [W-EDGE_W-1:0] lvl_out,
  output logic [EDGE_W-1:0] rise,
  output logic [EDGE_W-1:0] fall
);

  logic [W-1:0] stage_q [STAGES];
  logic [EDGE_W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
      prev_q <= RST_VAL[EDGE_W-1:0];
    end else begin
      stage_q[0] <= async_in;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      prev_q <= stage_q[STAGES-1][EDGE_W-1:0];
    end
  end

  genvar g;
  generate
    for (g = 0; g < EDGE_W; g++) begin : g_edge
      assign rise[g] = stage_q[STAGES-1][g] & ~prev_q[g];
      assign fall[g] = ~stage_q[STAGES-1][g] & prev_q[g];
    end
  endgenerate

  assign lvl_out = stage_q[STAGES-1][W-1:EDGE_W];

endmodule

// File: rtl/limit_ram.sv
module limit_ram #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic [ADDR_W-1:0] rb_addr,
  output logic [DATA_W-1:0] rb_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Read-before-write on both read ports: block RAM friendly.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    ra_data <= mem[ra_addr];
    rb_data <= mem[rb_addr];
  end

  // R2 / R4: a write strobe leaves its word in the addressed entry.
  a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/limit_frame.sv
module limit_frame
  import limit_store_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sel_rise,
  input  logic              sel_fall,
  input  logic              din,
  input  logic [DATA_W-1:0] ra_data,
  output logic [ADDR_W-1:0] ra_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              dout
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int BIT_W = $clog2(DATA_W);
  localparam int WIX_W = ADDR_W + 1;

  frame_state_e      state_q;
  logic [OP_W-1:0]   op_sr;
  logic [ADDR_W-1:0] addr_sr;
  logic [DATA_W-1:0] data_sr;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  out_idx;
  logic [WIX_W-1:0]  word_idx;
  logic [OP_W-1:0]   op_next;
  logic [DATA_W-1:0] data_next;

  assign op_next   = {op_sr[OP_W-2:0], din};
  assign data_next = {din, data_sr[DATA_W-1:1]};
  assign ra_addr   = addr_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      op_sr    <= '0;
      addr_sr  <= '0;
      data_sr  <= '0;
      cnt_q    <= '0;
      out_idx  <= '0;
      word_idx <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      dout     <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (sel_rise) begin
        if (state_q == ST_HOLD) begin
          wr_en   <= 1'b1;
          wr_addr <= addr_sr;
          wr_data <= data_sr;
        end
        state_q <= ST_IDLE;
        dout    <= 1'b0;
      end else if (sel_fall) begin
        state_q  <= ST_OPCODE;
        cnt_q    <= '0;
        op_sr    <= '0;
        word_idx <= '0;
        out_idx  <= '0;
      end else if (sclk_rise) begin
        case (state_q)
          ST_OPCODE: begin
            op_sr <= op_next;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(OP_W - 1)) begin
              cnt_q <= '0;
              case (op_next)
                OP_WRITE_ONE: state_q <= ST_WADDR;
                OP_WRITE_ALL: state_q <= ST_BULK;
                OP_READ_ONE:  state_q <= ST_RADDR;
                default:      state_q <= ST_SKIP;
              endcase
            end
          end
          ST_WADDR, ST_RADDR: begin
            addr_sr <= {addr_sr[ADDR_W-2:0], din};
            cnt_q   <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(ADDR_W - 1)) begin
              cnt_q   <= '0;
              out_idx <= '0;
              state_q <= (state_q == ST_WADDR) ? ST_WDATA : ST_RDOUT;
            end
          end
          ST_WDATA: begin
            data_sr <= data_next;
            cnt_q   <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(DATA_W - 1)) state_q <= ST_HOLD;
          end
          ST_BULK: begin
            data_sr <= data_next;
            cnt_q   <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(DATA_W - 1)) begin
              cnt_q    <= '0;
              wr_en    <= 1'b1;
              wr_addr  <= word_idx[ADDR_W-1:0];
              wr_data  <= data_next;
              word_idx <= word_idx + 1'b1;
              if (word_idx == WIX_W'(DEPTH - 1)) state_q <= ST_SKIP;
            end
          end
          default: ;
        endcase
      end else if (sclk_fall && state_q == ST_RDOUT) begin
        if (out_idx < CNT_W'(DATA_W)) begin
          dout    <= ra_data[out_idx[BIT_W-1:0]];
          out_idx <= out_idx + 1'b1;
        end else begin
          dout <= 1'b0;
        end
      end
    end
  end

  // R7: outside a frame the return line is quiet.
  a_r7_dout_idle: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> !dout);

  // R6 / R8: only a read frame ever drives a one on the return line.
  a_r6_dout_in_read: assert property (@(posedge clk) disable iff (rst)
    dout |-> (state_q == ST_RDOUT));

  // R8: a frame that has settled into the discard state never writes.
  a_r8_skip_no_write: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SKIP && $past(state_q == ST_SKIP)) |-> !wr_en);

  // R4: writes are single-cycle strobes, never back to back.
  a_r4_write_spacing: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

endmodule

// File: rtl/limit_store_slave.sv
module limit_store_slave #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_cs_n,
  input  logic              ser_din,
  output logic              ser_dout,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int SYNC_W = 3;
  localparam int EDGE_W = 2;

  logic [EDGE_W-1:0]        rise, fall;
  logic [SYNC_W-EDGE_W-1:0] din_lvl;
  logic                     wr_en;
  logic [ADDR_W-1:0]        wr_addr, ra_addr;
  logic [DATA_W-1:0]        wr_data, ra_data;

  // bit0 serial clock, bit1 select, bit2 data
  limit_in_sync #(
    .W(SYNC_W), .EDGE_W(EDGE_W), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)
  ) u_sync (
    .clk(clk), .rst(rst),
    .async_in({ser_din, ser_cs_n, ser_clk}),
    .lvl_out(din_lvl), .rise(rise), .fall(fall)
  );

  limit_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst(rst),
    .sclk_rise(rise[0]), .sclk_fall(fall[0]),
    .sel_rise(rise[1]), .sel_fall(fall[1]),
    .din(din_lvl[0]),
    .ra_data(ra_data), .ra_addr(ra_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dout(ser_dout)
  );

  limit_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .rst(rst),
    .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .ra_addr(ra_addr), .ra_data(ra_data),
    .rb_addr(rd_addr), .rb_data(rd_data)
  );

endmodule

// File: tb/limit_store_slave_bench.sv
`timescale 1ns/1ps
module limit_store_slave_bench;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int HALF = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, din = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic dout;
  logic [DW-1:0] rd_data;
  logic [DW-1:0] model [DEPTH];
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  limit_store_slave u_limit_store_slave (
    .clk(clk), .rst(rst), .ser_clk(sclk), .ser_cs_n(cs_n), .ser_din(din),
    .ser_dout(dout), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    din = b; wait_cyc(HALF); sclk = 1'b1; wait_cyc(HALF); sclk = 1'b0;
  endtask

  task automatic send_msb(input logic [7:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic send_lsb(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) send_bit(v[i]);
  endtask

  task automatic begin_frame;
    cs_n = 1'b0; wait_cyc(HALF);
  endtask

  task automatic end_frame;
    wait_cyc(HALF); cs_n = 1'b1; wait_cyc(2 * HALF);
    check("R7 dout low with select high", dout, 0);
  endtask

  // R1 R2 R3: single write, nbits < 8 aborts it
  task automatic write_one(input logic [3:0] a, input logic [7:0] v, input int nbits);
    begin_frame; send_msb(8'b1100, 4); send_msb({4'h0, a}, 4); send_lsb(v, nbits); end_frame;
    if (nbits == 8) model[a] = v;
  endtask

  // R4 R5: whole-table write, nwords full words plus tail bits
  task automatic write_all(input int nwords, input int tail);
    logic [7:0] v;
    begin_frame; send_msb(8'b1101, 4);
    for (int w = 0; w < nwords; w++) begin
      v = 8'($urandom); send_lsb(v, 8); model[w] = v;
    end
    if (tail > 0) send_lsb(8'($urandom), tail);
    end_frame;
  endtask

  // R6: serial read, sampled just before each rise
  task automatic read_one(input logic [3:0] a);
    logic [7:0] got;
    begin_frame; send_msb(8'b1011, 4); send_msb({4'h0, a}, 4);
    for (int i = 0; i < 8; i++) begin
      wait_cyc(HALF); got[i] = dout; sclk = 1'b1; wait_cyc(HALF); sclk = 1'b0;
    end
    check("R6 serial read word", got, model[a]);
    end_frame;
  endtask

  // R8: unknown code, dout must stay 0 while bits keep coming
  task automatic bad_op(input logic [3:0] code);
    begin_frame; send_msb({4'h0, code}, 4);
    for (int i = 0; i < 12; i++) begin
      send_bit(1'($urandom)); wait_cyc(2);
      check("R8 dout quiet on unknown code", dout, 0);
    end
    end_frame;
  endtask

  task automatic verify_all(input string req);
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr = AW'(a); wait_cyc(2);
      check(req, rd_data, model[a]);
    end
  endtask

  // R9: same-cycle serial write and parallel read of one entry
  task automatic collide(input logic [3:0] a);
    logic [7:0] oldv, newv;
    oldv = model[a]; newv = ~oldv ^ 8'h5a;
    rd_addr = a;
    begin_frame; send_msb(8'b1100, 4); send_msb({4'h0, a}, 4); send_lsb(newv, 8);
    wait_cyc(HALF); cs_n = 1'b1;
    wait_cyc(4);
    check("R9 old word in write cycle", rd_data, oldv);
    wait_cyc(1);
    check("R9 new word next cycle", rd_data, newv);
    model[a] = newv;
    wait_cyc(2 * HALF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    wait_cyc(4); rst = 1'b0; wait_cyc(2);
    check("R7 dout zero after reset", dout, 0);

    write_all(16, 0);
    verify_all("R4 whole-table order");
    write_one(4'h0, 8'hc3, 8);
    write_one(4'hf, 8'h81, 8);
    verify_all("R2 single write");
    read_one(4'h0);
    read_one(4'hf);
    write_one(4'h6, 8'h77, 5);
    verify_all("R3 aborted single write");
    write_all(3, 4);
    verify_all("R5 aborted whole-table write");
    bad_op(4'b0000); bad_op(4'b1111); bad_op(4'b1110); bad_op(4'b0011);
    verify_all("R8 table unchanged by unknown code");
    collide(4'h5);
    collide(4'hf);

    for (int n = 0; n < 30; n++) begin
      case ($urandom % 4)
        0: write_one(4'($urandom), 8'($urandom), 8);
        1: write_one(4'($urandom), 8'($urandom), 1 + int'($urandom % 7));
        2: read_one(4'($urandom));
        default: collide(4'($urandom));
      endcase
    end
    verify_all("R1 R2 R9 final table");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule